// File: doc/BRIEF.md
# Four-Mode Dual Timer/Counter

Two 8+8-bit timer/counters share one configuration byte and one run/flag byte. Each timer counts machine cycles or falling edges on its own event pin. Counting can be held off by a per-timer gate pin. A two-bit mode field chooses one of four layouts:

- a 13-bit cascade (five low bits feeding the high byte);
- a 16-bit cascade;
- an 8-bit counter reloaded from the high byte;
- a fourth layout, which splits timer 0 into two 8-bit timers and freezes timer 1.

Software reaches the registers through a write port and a combinational read port, using a 3-bit address. Counting advances only on cycles where the machine-cycle strobe is high. Each overflow flag is a level output that stays high until software writes it low.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset every register reads 0x00 and both `ovf_o` bits are low.
- R2: Register map, by address:
  - 0: configuration. Timer 0 uses bits [3:0] and timer 1 uses bits [7:4]. Within each nibble, [1:0] is the mode (00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split/halt), bit 2 selects event counting and bit 3 is the gate enable.
  - 1: control. Bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0, bit 3 is flag 1, and bits [7:4] read 0.
  - 2 and 3: timer 0 low and high.
  - 4 and 5: timer 1 low and high.
  - 6 and 7: read 0.
- R3: A timer advances only while its run bit is 1 and either its gate enable is 0 or its gate pin is high.
- R4: With event counting selected, the count advances by one on a strobe where the event pin is sampled low and the previous strobe sampled it high. With event counting deselected, it advances once per strobe.
- R5: In mode 00 the low byte bits [4:0] and the high byte form a 13-bit count. The step from 0x1FFF to 0 sets the flag, and low bits [7:5] never change by counting.
- R6: In mode 01 the two bytes form a 16-bit count. The step from 0xFFFF to 0 sets the flag, and counting continues from zero.
- R7: In mode 10 the low byte counts. Its step past 0xFF loads the high byte value and sets the flag, and counting never alters the high byte.
- R8: With timer 0 in mode 11:
  - Its low byte is an 8-bit timer/counter using timer 0's select, gate, run bit and flag.
  - Its high byte is an 8-bit cycle timer run by run bit 1, and its wrap sets flag 1.
- R9: Timer 1 in mode 11 holds its count.
- R10: While timer 0 is in mode 11, timer 1 in modes 00, 01 and 10 counts on every strobe (subject to its own event select), regardless of its run bit and gate. Its overflows do not set flag 1.
- R11: Priority and flag behaviour:
  - A count-register write wins over an increment in the same cycle.
  - A write of 0 to a flag clears it, unless an overflow of that flag occurs in the same cycle, in which case the flag stays set.
  - A flag stays high until written low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_stb_i | input | 1 | Machine-cycle strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| evt_i | input | 2 | Event pins, index = timer |
| gate_pin_i | input | 2 | Gate pins, index = timer |
| ovf_o | output | 2 | Overflow flags, index = flag |

## Verification
Every cycle, the assertions check the following:
- the mode-10 reload and its untouched high byte;
- the frozen upper low-byte bits in mode 00;
- the held count of timer 1 in mode 11;
- a stopped timer 0 low byte;
- stickiness of the flags;
- that flag 1 stays low in the split layout unless the high byte of timer 0 wraps.

Only the bench scenarios can show the following:
- exact count values across 13-bit and 16-bit rollovers;
- falling-edge detection on the event pin;
- gate-pin qualification;
- free running of timer 1 during the split;
- the outcome of same-cycle write/increment and clear/overflow collisions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_TMR  = 2;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_T0LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_T0HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_T1LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_T1HI = 3'd5;

  typedef enum logic [1:0] {
    MD_13    = 2'b00,
    MD_16    = 2'b01,
    MD_8RL   = 2'b10,
    MD_SPLIT = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      evt_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_evt_sample.sv
module tmr_evt_sample #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    prev_q[g] <= 1'b0;
      else if (stb_i) prev_q[g] <= evt_i[g];
    end
    assign fall_o[g] = stb_i & prev_q[g] & ~evt_i[g];
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned PRE_W = 5,
  parameter bit          SPLIT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_mode_e    mode_i,
  input  logic         tick_i,
  input  logic         tick_hi_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ovf_o,
  output logic         ovf_hi_o
);
  localparam int unsigned S13_W = PRE_W + W + 1;
  localparam int unsigned S16_W = 2 * W + 1;
  localparam logic [W-1:0] ONE_B = W'(1);

  logic [W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [S13_W-1:0] s13;
  logic [S16_W-1:0] s16;
  logic [W-1:0] spl_lo_n, spl_hi_n;
  logic         spl_ovf, spl_ovf_hi;

  assign s13 = {1'b0, hi_q, lo_q[PRE_W-1:0]} + {{(S13_W-1){1'b0}}, 1'b1};
  assign s16 = {1'b0, hi_q, lo_q} + {{(S16_W-1){1'b0}}, 1'b1};

  if (SPLIT) begin : g_split
    assign spl_lo_n   = tick_i ? lo_q + ONE_B : lo_q;
    assign spl_ovf    = tick_i & (&lo_q);
    assign spl_hi_n   = tick_hi_i ? hi_q + ONE_B : hi_q;
    assign spl_ovf_hi = tick_hi_i & (&hi_q);
  end else begin : g_halt
    logic unused_tick_hi;
    assign unused_tick_hi = tick_hi_i;
    assign spl_lo_n   = lo_q;
    assign spl_hi_n   = hi_q;
    assign spl_ovf    = 1'b0;
    assign spl_ovf_hi = 1'b0;

    AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MD_SPLIT && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q))); // R9
  end

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (mode_i)
      MD_13: if (tick_i) begin
        lo_n  = {lo_q[W-1:PRE_W], s13[PRE_W-1:0]};
        hi_n  = s13[PRE_W +: W];
        ovf_o = s13[S13_W-1];
      end
      MD_16: if (tick_i) begin
        lo_n  = s16[W-1:0];
        hi_n  = s16[W +: W];
        ovf_o = s16[S16_W-1];
      end
      MD_8RL: if (tick_i) begin
        if (&lo_q) begin
          lo_n  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_n  = lo_q + ONE_B;
        end
      end
      MD_SPLIT: begin
        lo_n     = spl_lo_n;
        hi_n     = spl_hi_n;
        ovf_o    = spl_ovf;
        ovf_hi_o = spl_ovf_hi;
      end
      default: ;
    endcase
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_RELOAD_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_8RL && tick_i && (&lo_q) && !wr_lo_i) |=> (lo_q == $past(hi_q))); // R7
  AST_RELOAD_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_8RL && !wr_hi_i) |=> $stable(hi_q)); // R7
  AST_M13_TOP_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_13 && !wr_lo_i) |=> $stable(lo_q[W-1:PRE_W])); // R5
endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_stb_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_TMR-1:0]  evt_i,
  input  logic [N_TMR-1:0]  gate_pin_i,
  output logic [N_TMR-1:0]  ovf_o
);
  logic [DATA_W-1:0] cfg_q;
  logic [N_TMR-1:0]  run_q, flag_q, flag_set, fall;
  tmr_cfg_t          cfg0, cfg1;
  logic              wr_cfg, wr_ctl;
  logic              t0_split, run0_ok, run1_ok, tick0, tick1, tick0_hi;
  logic [DATA_W-1:0] t0_lo, t0_hi, t1_lo, t1_hi;
  logic              t0_ovf, t0_ovf_hi, t1_ovf, t1_unused_ovf_hi;

  assign cfg0   = tmr_cfg_t'(cfg_q[3:0]);
  assign cfg1   = tmr_cfg_t'(cfg_q[7:4]);
  assign wr_cfg = wr_en_i && (wr_addr_i == A_CFG);
  assign wr_ctl = wr_en_i && (wr_addr_i == A_CTL);

  tmr_evt_sample #(.N(N_TMR)) u_evt (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(cyc_stb_i), .evt_i(evt_i), .fall_o(fall)
  );

  assign t0_split = (cfg0.mode == MD_SPLIT);
  assign run0_ok  = run_q[0] & (~cfg0.gate_en | gate_pin_i[0]);
  // split layout takes timer 1's run bit away: it runs unconditionally
  assign run1_ok  = t0_split | (run_q[1] & (~cfg1.gate_en | gate_pin_i[1]));
  assign tick0    = cyc_stb_i & run0_ok & (cfg0.evt_sel ? fall[0] : 1'b1);
  assign tick1    = cyc_stb_i & run1_ok & (cfg1.evt_sel ? fall[1] : 1'b1);
  assign tick0_hi = cyc_stb_i & run_q[1];

  tmr_core #(.W(DATA_W), .PRE_W(5), .SPLIT(1'b1)) u_t0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(cfg0.mode), .tick_i(tick0),
    .tick_hi_i(tick0_hi),
    .wr_lo_i(wr_en_i && wr_addr_i == A_T0LO), .wr_hi_i(wr_en_i && wr_addr_i == A_T0HI),
    .wdata_i(wr_data_i), .lo_o(t0_lo), .hi_o(t0_hi), .ovf_o(t0_ovf), .ovf_hi_o(t0_ovf_hi)
  );

  tmr_core #(.W(DATA_W), .PRE_W(5), .SPLIT(1'b0)) u_t1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(cfg1.mode), .tick_i(tick1),
    .tick_hi_i(1'b0),
    .wr_lo_i(wr_en_i && wr_addr_i == A_T1LO), .wr_hi_i(wr_en_i && wr_addr_i == A_T1HI),
    .wdata_i(wr_data_i), .lo_o(t1_lo), .hi_o(t1_hi), .ovf_o(t1_ovf),
    .ovf_hi_o(t1_unused_ovf_hi)
  );

  assign flag_set[0] = t0_ovf;
  assign flag_set[1] = t0_split ? t0_ovf_hi : t1_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= wr_data_i;
      if (wr_ctl) begin
        run_q  <= wr_data_i[1:0];
        flag_q <= wr_data_i[3:2] | flag_set;
      end else begin
        flag_q <= flag_q | flag_set;
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CFG:   rd_data_o = cfg_q;
      A_CTL:   rd_data_o = {4'h0, flag_q, run_q};
      A_T0LO:  rd_data_o = t0_lo;
      A_T0HI:  rd_data_o = t0_hi;
      A_T1LO:  rd_data_o = t1_lo;
      A_T1HI:  rd_data_o = t1_hi;
      default: rd_data_o = '0;
    endcase
  end

  assign ovf_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && !wr_ctl) |=> flag_q[0]); // R11
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[0] && !(wr_en_i && wr_addr_i == A_T0LO)) |=> $stable(t0_lo)); // R3
  AST_SPLIT_T1_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t0_split && !t0_ovf_hi && !wr_ctl && !flag_q[1]) |=> !flag_q[1]); // R10
endmodule

// File: tb/dual_tmr_unit_test.sv
`timescale 1ns/1ps
module dual_tmr_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stb = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] evt = '0, gpin = '0, ovf;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_tmr_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_stb_i(stb), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .evt_i(evt),
    .gate_pin_i(gpin), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [7:0] cfg, ctl, l0, h0, l1, h1, n, e_l0, e_h0, e_l1, e_h1, e_ctl;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h01, 8'h01, 8'hFE, 8'hFF, 8'h00, 8'h00, 8'd3, 8'h01, 8'h00, 8'h00, 8'h00, 8'h05}, // R6
    '{8'h00, 8'h01, 8'hFE, 8'hFF, 8'h00, 8'h00, 8'd3, 8'hE1, 8'h00, 8'h00, 8'h00, 8'h05}, // R5
    '{8'h02, 8'h01, 8'hFD, 8'h55, 8'h00, 8'h00, 8'd4, 8'h56, 8'h55, 8'h00, 8'h00, 8'h05}, // R7
    '{8'h10, 8'h02, 8'h00, 8'h00, 8'hFF, 8'h00, 8'd2, 8'h00, 8'h00, 8'h01, 8'h01, 8'h02}, // R6
    '{8'h09, 8'h01, 8'h10, 8'h00, 8'h00, 8'h00, 8'd5, 8'h10, 8'h00, 8'h00, 8'h00, 8'h01}, // R3
    '{8'h03, 8'h03, 8'hFF, 8'hFE, 8'h20, 8'h00, 8'd2, 8'h01, 8'h00, 8'h22, 8'h00, 8'h0F}, // R8
    '{8'h30, 8'h02, 8'h00, 8'h00, 8'h44, 8'h33, 8'd4, 8'h00, 8'h00, 8'h44, 8'h33, 8'h02}, // R9
    '{8'h13, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}  // R10
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); stb = 1'b1;
      @(negedge clk); stb = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset read", d, 8'h00);
    end
    check("R1 flags", {6'b0, ovf}, 8'h00);

    for (int v = 0; v < 8; v++) begin
      wr(3'd1, 8'h00);
      wr(3'd0, VEC[v].cfg);
      wr(3'd2, VEC[v].l0); wr(3'd3, VEC[v].h0);
      wr(3'd4, VEC[v].l1); wr(3'd5, VEC[v].h1);
      wr(3'd1, VEC[v].ctl);
      pulse(int'(VEC[v].n));
      rd(3'd2, d); check("R5/R6/R7/R8 t0 lo", d, VEC[v].e_l0);
      rd(3'd3, d); check("R5/R6/R7/R8 t0 hi", d, VEC[v].e_h0);
      rd(3'd4, d); check("R9/R10 t1 lo", d, VEC[v].e_l1);
      rd(3'd5, d); check("R9/R10 t1 hi", d, VEC[v].e_h1);
      rd(3'd1, d); check("R11 ctl/flags", d, VEC[v].e_ctl);
      check("R11 ovf_o level", {6'b0, ovf}, {6'b0, VEC[v].e_ctl[3:2]});
    end

    // R2 map readback
    rd(3'd0, d); check("R2 cfg readback", d, 8'h13);
    rd(3'd6, d); check("R2 unused address", d, 8'h00);

    // R4 event counting on falling edges
    wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    evt[0] = 1'b1; pulse(1);
    evt[0] = 1'b0; pulse(1);
    pulse(1);
    evt[0] = 1'b1; pulse(1);
    evt[0] = 1'b0; pulse(1);
    rd(3'd2, d); check("R4 falling edges", d, 8'h02);
    pulse(2);
    rd(3'd2, d); check("R4 steady low no count", d, 8'h02);

    // R3 gate pin high lets it run
    wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gpin[0] = 1'b1; wr(3'd1, 8'h01);
    pulse(3);
    rd(3'd2, d); check("R3 gate high", d, 8'h03);
    gpin[0] = 1'b0;
    pulse(2);
    rd(3'd2, d); check("R3 gate low stops", d, 8'h03);

    // R11 flag clear loses to same-cycle overflow
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    @(negedge clk); stb = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h01;
    @(negedge clk); stb = 1'b0; wr_en = 1'b0;
    check("R11 set beats clear", {7'b0, ovf[0]}, 8'h01);
    rd(3'd2, d); check("R11 wrapped lo", d, 8'h00);
    wr(3'd1, 8'h01);
    check("R11 clear alone", {7'b0, ovf[0]}, 8'h00);

    // R11 write beats increment
    @(negedge clk); stb = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h80;
    @(negedge clk); stb = 1'b0; wr_en = 1'b0;
    rd(3'd2, d); check("R11 write priority", d, 8'h80);
    pulse(1);
    rd(3'd2, d); check("R11 counts after write", d, 8'h81);

    done = 1'b1;
    finish_run();
  end
endmodule